// File: doc/BRIEF.md
# Event-Driven Peak Acquisition Sequencer

This block is the control logic of one particle-detection channel. A threshold comparator reports when a shaped pulse is above the detection level, a peak-hold stage follows the pulse amplitude, and an 8-bit successive-approximation converter digitises the held value. The sequencer watches the comparator and waits until the pulse has passed its peak before it declares an event. It then freezes the peak-hold stage, starts the converter, waits for the converter's done flag, discharges the hold stage, releases the converter and returns to idle.

The comparator output is asynchronous to the system clock, so it passes through a synchroniser before its falling edge is detected. While a conversion or its recovery is running, further comparator activity is not queued. Each such edge is reported on a separate strobe. If the converter never signals completion, a timeout forces the normal teardown order and raises an error strobe. The analog peak detector, the comparator and the converter core sit outside this block.

Top module: `peak_acq_seq`

## Requirements
- R1: While rst_ni is low, hold_o, conv_o, pk_rst_o, evt_o, drop_o and tmo_o are all 0.
- R2: Only a 1-to-0 transition of cmp_i declares an event, and a rising cmp_i has no effect. With the default two-stage synchroniser, hold_o and a one-cycle evt_o pulse go to 1 on the second rising edge after the first edge that samples cmp_i low.
- R3: conv_o rises one cycle after hold_o rises, and hold_o stays 1 throughout.
- R4: With conv_o at 1, the sequencer first waits for done_i to be sampled 0 (converter busy) and then for it to be sampled 1. pk_rst_o rises on the edge after done_i is sampled 1, while conv_o is still 1.
- R5: conv_o falls exactly one cycle after pk_rst_o rises, with hold_o and pk_rst_o both still 1.
- R6: hold_o and pk_rst_o fall together REC_CYC cycles after conv_o falls (default 2). After that, a new event is accepted.
- R7: A comparator falling edge seen while the sequencer is not idle produces a one-cycle drop_o pulse. It produces no evt_o and no extra conversion, and the held value is unchanged.
- R8: If done_i has not completed the busy-then-done sequence within TMO_CYC cycles of conv_o rising (default 32), tmo_o pulses for one cycle together with the rise of pk_rst_o, and the R5/R6 teardown follows. conv_o is then high for TMO_CYC+1 cycles.
- R9: hold_o stays 1 from the event until teardown, so the converter result equals the peak amplitude that the pulse reached before the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 1 | Threshold comparator output, asynchronous |
| done_i | input | 1 | Converter done flag, low while busy |
| hold_o | output | 1 | Freeze the peak-hold stage |
| conv_o | output | 1 | Convert request to the converter |
| pk_rst_o | output | 1 | Discharge the peak-hold capacitor |
| evt_o | output | 1 | One-cycle strobe per accepted event |
| drop_o | output | 1 | One-cycle strobe per ignored falling edge |
| tmo_o | output | 1 | One-cycle strobe when the done timeout expires |

## Verification
The hardest situation to reach is a second comparator pulse that falls while a conversion is in flight. Its amplitude is larger than the held value, so a hold stage that is not frozen would corrupt the result. The driver fires such an intruding pulse a few cycles after hold_o rises. The converter stub then must still return the first peak, and exactly one drop strobe must appear. The timeout path is reached by switching the converter stub into a mode where done_i never returns. The bench then measures how long conv_o stays high, and checks that the channel accepts a normal event afterwards.

// File: rtl/peak_acq_pkg.sv
package peak_acq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_BUSY,
    ST_WAIT,
    ST_DISCH,
    ST_RECOV
  } seq_state_e;
endpackage

// File: rtl/cmp_edge_sync.sv
module cmp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic fall_o
);
  logic [STAGES-1:0] sq;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sq[0] <= 1'b0;
        else         sq[0] <= async_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sq[g] <= 1'b0;
        else         sq[g] <= sq[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sq[STAGES-1];

  assign fall_o = prev_q & ~sq[STAGES-1];

  a_r2_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int CW  = 6,
  parameter int MAX = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;

  a_r8_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_o) <= MAX);
endmodule

// File: rtl/peak_acq_ctrl.sv
module peak_acq_ctrl
  import peak_acq_pkg::*;
#(
  parameter int REC_CYC = 2,
  parameter int TMO_CYC = 32,
  parameter int CW      = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fall_i,
  input  logic          done_i,
  input  logic [CW-1:0] cnt_i,
  output logic          tmr_clr_o,
  output logic          tmr_en_o,
  output logic          hold_o,
  output logic          conv_o,
  output logic          pk_rst_o,
  output logic          evt_o,
  output logic          drop_o,
  output logic          tmo_o
);
  localparam logic [CW-1:0] TMO_LAST = CW'(TMO_CYC - 1);
  localparam logic [CW-1:0] REC_LAST = CW'(REC_CYC - 1);

  seq_state_e st_q, st_d;
  logic       evt_d, tmo_d;

  always_comb begin
    st_d  = st_q;
    evt_d = 1'b0;
    tmo_d = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (fall_i) begin st_d = ST_HOLD; evt_d = 1'b1; end
      ST_HOLD:  st_d = ST_BUSY;
      ST_BUSY:  if (cnt_i == TMO_LAST) begin st_d = ST_DISCH; tmo_d = 1'b1; end
                else if (!done_i)      st_d = ST_WAIT;
      ST_WAIT:  if (done_i)                 st_d = ST_DISCH;
                else if (cnt_i == TMO_LAST) begin st_d = ST_DISCH; tmo_d = 1'b1; end
      ST_DISCH: st_d = ST_RECOV;
      ST_RECOV: if (cnt_i == REC_LAST) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      evt_o  <= 1'b0;
      drop_o <= 1'b0;
      tmo_o  <= 1'b0;
    end else begin
      st_q   <= st_d;
      evt_o  <= evt_d;
      drop_o <= fall_i && (st_q != ST_IDLE);
      tmo_o  <= tmo_d;
    end

  // timer restarts on entry to the conversion wait and to recovery
  assign tmr_clr_o = (st_q == ST_HOLD) || (st_q == ST_DISCH);
  assign tmr_en_o  = (st_q == ST_BUSY) || (st_q == ST_WAIT) || (st_q == ST_RECOV);

  assign hold_o   = (st_q != ST_IDLE);
  assign conv_o   = (st_q == ST_BUSY) || (st_q == ST_WAIT) || (st_q == ST_DISCH);
  assign pk_rst_o = (st_q == ST_DISCH) || (st_q == ST_RECOV);

  a_r2_evt_from_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> $past(fall_i));
  a_r3_conv_after_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_o) |-> $past(hold_o));
  a_r4_disch_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pk_rst_o) |-> ($past(done_i) || tmo_o));
  a_r5_conv_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(conv_o) |-> (pk_rst_o && hold_o));
  a_r6_joint_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> $fell(pk_rst_o));
  a_r7_drop_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> (!evt_o && $past(fall_i)));
  a_r8_tmo_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> ($past(cnt_i) == TMO_LAST));
endmodule

// File: rtl/peak_acq_seq.sv
module peak_acq_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int REC_CYC     = 2,
  parameter int TMO_CYC     = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_i,
  input  logic done_i,
  output logic hold_o,
  output logic conv_o,
  output logic pk_rst_o,
  output logic evt_o,
  output logic drop_o,
  output logic tmo_o
);
  localparam int CNT_MAX = (REC_CYC > TMO_CYC) ? REC_CYC : TMO_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic          fall;
  logic          tmr_clr, tmr_en;
  logic [CW-1:0] cnt;

  cmp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(cmp_i),
    .fall_o (fall)
  );

  seq_timer #(.CW(CW), .MAX(CNT_MAX)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tmr_clr),
    .en_i  (tmr_en),
    .cnt_o (cnt)
  );

  peak_acq_ctrl #(.REC_CYC(REC_CYC), .TMO_CYC(TMO_CYC), .CW(CW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fall_i   (fall),
    .done_i   (done_i),
    .cnt_i    (cnt),
    .tmr_clr_o(tmr_clr),
    .tmr_en_o (tmr_en),
    .hold_o   (hold_o),
    .conv_o   (conv_o),
    .pk_rst_o (pk_rst_o),
    .evt_o    (evt_o),
    .drop_o   (drop_o),
    .tmo_o    (tmo_o)
  );
endmodule

// File: tb/sim_peak_acq_seq.sv
`timescale 1ns/1ps
module sim_peak_acq_seq;
  localparam int CLK_PERIOD = 100;
  localparam int REC       = 2;
  localparam int TMO       = 32;
  localparam int THR       = 20;
  localparam int CONV_LAT  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp, done;
  logic hold, conv, pk_rst, evt, drop, tmo;

  int   amp = 0;
  bit   hang = 1'b0;
  bit   finished = 1'b0;
  logic [7:0] peak_st;
  logic [7:0] result;
  logic       conv_q;
  int         lat;

  int checks = 0, errors = 0;
  int exp_q[$];
  int n_evt = 0, n_drop = 0, n_tmo = 0;
  int conv_len = 0, last_len = 0, rec_cnt = 0;
  logic p_hold = 0, p_conv = 0, p_pk = 0, p_done = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmp = (amp > THR);

  peak_acq_seq #(.SYNC_STAGES(2), .REC_CYC(REC), .TMO_CYC(TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp), .done_i(done),
    .hold_o(hold), .conv_o(conv), .pk_rst_o(pk_rst),
    .evt_o(evt), .drop_o(drop), .tmo_o(tmo)
  );

  // peak-hold stub
  always @(posedge clk or negedge rst_n)
    if (!rst_n)               peak_st <= '0;
    else if (pk_rst)          peak_st <= '0;
    else if (!hold && amp > int'(peak_st)) peak_st <= 8'(amp);

  // converter stub: done idles high, low while busy
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done <= 1'b1; conv_q <= 1'b0; lat <= 0; result <= '0;
    end else begin
      conv_q <= conv;
      if (conv && !conv_q) begin
        done <= 1'b0; lat <= CONV_LAT;
      end else if (conv && !done && !hang) begin
        if (lat == 1) begin done <= 1'b1; result <= peak_st; end
        lat <= lat - 1;
      end else if (!conv) done <= 1'b1;
    end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) if (rst_n) begin
    if (evt)  n_evt++;
    if (drop) n_drop++;
    if (tmo)  n_tmo++;
    if (conv) conv_len++;
    if (conv && !p_conv) chk(p_hold == 1'b1, "R3 hold before conv", int'(p_hold), 1);
    if (pk_rst && !p_pk)  chk(conv == 1'b1, "R4 conv high at pk_rst rise", int'(conv), 1);
    if (done && !p_done && conv) begin
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected result", int'(result), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(result) == e, "R9 converted peak", int'(result), e);
      end
    end
    if (!conv && p_conv) begin
      chk(pk_rst && hold && p_pk, "R5 conv drops under pk_rst", int'({hold, pk_rst, p_pk}), 7);
      last_len = conv_len; conv_len = 0; rec_cnt = 0;
    end else if (hold) rec_cnt++;
    if (!hold && p_hold) begin
      rec_cnt++;
      chk(!pk_rst && p_pk, "R6 hold and pk_rst fall together", int'(pk_rst), 0);
      chk(rec_cnt == REC, "R6 recovery length", rec_cnt, REC);
    end
    p_hold = hold; p_conv = conv; p_pk = pk_rst; p_done = done;
  end

  task automatic send_pulse(int pk, bit expect_res, bit intrude);
    int ev0, dr0;
    ev0 = n_evt; dr0 = n_drop;
    @(negedge clk); amp = pk / 2;
    @(negedge clk); amp = pk;
    @(negedge clk);
    chk(hold == 1'b0, "R2 rising edge ignored", int'(hold), 0);
    amp = 0;
    if (expect_res) exp_q.push_back(pk);
    @(negedge clk);
    @(negedge clk);
    chk(hold == 1'b0, "R2 no early hold", int'(hold), 0);
    @(negedge clk);
    chk(hold && evt, "R2 hold and evt after fall", int'({hold, evt}), 3);
    @(negedge clk);
    chk(!evt && hold, "R2 evt single cycle", int'({hold, evt}), 2);
    if (intrude) begin
      @(negedge clk); amp = pk + 40;
      repeat (2) @(negedge clk);
      amp = 0;
    end
    while (hold || conv || pk_rst) @(negedge clk);
    chk(n_evt == ev0 + 1, "R7 one event per sequence", n_evt - ev0, 1);
    if (intrude) chk(n_drop == dr0 + 1, "R7 drop strobe", n_drop - dr0, 1);
    else         chk(n_drop == dr0, "R7 no spurious drop", n_drop - dr0, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    chk({hold, conv, pk_rst, evt, drop, tmo} == 6'b0, "R1 reset outputs",
        int'({hold, conv, pk_rst, evt, drop, tmo}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({hold, conv, pk_rst} == 3'b0, "R1 idle after reset", int'({hold, conv, pk_rst}), 0);

    send_pulse(200, 1'b1, 1'b0);
    send_pulse(45,  1'b1, 1'b0);
    send_pulse(21,  1'b1, 1'b0);
    send_pulse(60,  1'b1, 1'b1);   // R7 intrusion during conversion
    send_pulse(255, 1'b1, 1'b0);   // R6 new event after teardown

    // R8 timeout path
    hang = 1'b1;
    t0 = n_tmo;
    send_pulse(150, 1'b0, 1'b0);
    chk(n_tmo == t0 + 1, "R8 timeout strobe", n_tmo - t0, 1);
    chk(last_len == TMO + 1, "R8 conv length on timeout", last_len, TMO + 1);
    hang = 1'b0;
    send_pulse(90, 1'b1, 1'b0);
    chk(n_tmo == t0 + 1, "R8 no timeout on normal run", n_tmo - t0, 1);

    chk(exp_q.size() == 0, "R9 all results seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule